// File: doc/BRIEF.md
# Iterative Signed Fractional Multiplier

This execution unit sits beside the integer pipeline of a 16-bit microcontroller core. It forms the signed product of a selected source operand and a fixed companion factor register. The full-width product is built from one small 8x8 unsigned multiplier that is reused once for each pair of operand bytes. The operands are first reduced to magnitudes, and the sum is negated at the end when the operand signs differ.

The unit returns the upper half of the product as a fraction-style result. It also returns a carry bit taken from the highest discarded product bit, sign and zero flags, and a write strobe with its destination index. One register index is never written, so a product aimed at it is dropped. A mode input picks the long variant, which also hands out the low half of the product. A speed input chooses between one multiplier pass per cycle and two cycles per pass.

The controller has four states. `ST_IDLE` waits for `start`. `ST_PASS` runs one byte-pair pass. `ST_HOLD` is the extra cycle of a pass in slow mode. `ST_FINAL` presents the result for one cycle. The transitions are: IDLE→PASS on an accepted start; PASS→PASS after a fast pass that is not the last; PASS→HOLD in slow mode; HOLD→PASS after a pass that is not the last; PASS→FINAL or HOLD→FINAL after the last pass; FINAL→IDLE always.

Top module: `fracmul_unit`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `wr_en`, `lo_wr_en` and `prefix_clr` are low.
- R2: In the done cycle, `result` equals bits 31..16 of the two's-complement product of `src_val` and `fac_val`, both treated as signed 16-bit values. This includes 0x8000 × 0x8000, which gives 0x4000.
- R3: In the done cycle, `flag_cy` equals product bit 15.
- R4: In the done cycle, `flag_s` equals product bit 31 and `flag_z` is high exactly when product bits 31..16 are all zero.
- R5: With `slow_mode` low at the accepted start, `done` is high in the 4th cycle after the start edge (one pass per cycle).
- R6: With `slow_mode` high at the accepted start, `done` is high in the 8th cycle after the start edge (two cycles per pass).
- R7: `busy` is high from the cycle after an accepted start through the done cycle and low in the cycle after it. `done` is a single-cycle pulse.
- R8: A `start` seen while `busy` is high is ignored. The running operation keeps its operands, destination and modes.
- R9: `wr_en` is high in the done cycle, with `wr_idx` equal to the sampled `dst_sel`, for every destination except index 4. For index 4, `wr_en` stays low.
- R10: With `long_mode` high at start, `lo_wr_en` is high in the done cycle and `lo_result` equals product bits 15..0. With `long_mode` low, `lo_wr_en` stays low.
- R11: `prefix_clr` is high in the done cycle and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; taken only when idle |
| src_val | input | 16 | Signed source operand |
| fac_val | input | 16 | Signed fixed factor register value |
| dst_sel | input | 4 | Destination register index |
| slow_mode | input | 1 | 1 = two cycles per multiplier pass |
| long_mode | input | 1 | 1 = also deliver the low product half |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Product bits 31..16 |
| lo_result | output | 16 | Product bits 15..0 |
| wr_en | output | 1 | Destination write strobe |
| lo_wr_en | output | 1 | Low-half write strobe (long mode) |
| wr_idx | output | 4 | Destination index for the write |
| flag_cy | output | 1 | Carry flag: product bit 15 |
| flag_s | output | 1 | Sign flag of the result |
| flag_z | output | 1 | Zero flag of the result |
| prefix_clr | output | 1 | Clears the instruction prefix flags |

## Verification
Counting from the edge that accepts `start`, the result, flags and write strobes are due 4 cycles later in fast mode and 8 cycles later in slow mode. They are valid in that cycle only, and everything is idle again one cycle after. The bench drives each operation on a falling edge and then steps exactly that number of falling edges. It confirms busy-without-done at every intermediate step, samples every output in the due cycle, and confirms the idle state one step later. Expected values come from a plain signed 32-bit multiply in the bench, applied across sweeps of corner operands, stepped source values and a pseudo-random stream.

// File: rtl/fracmul_pkg.sv
package fracmul_pkg;

    // Controller states of the iterative multiplier
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FINAL = 2'd3
    } fm_state_t;

endpackage

// File: rtl/fracmul_slice_mul.sv
// One unsigned slice-by-slice multiplier, reused for every byte pair.
module fracmul_slice_mul #(
    parameter int SLICE = 8
) (
    input  logic [SLICE-1:0]   x,
    input  logic [SLICE-1:0]   y,
    output logic [2*SLICE-1:0] p
);
    assign p = (2*SLICE)'(x) * (2*SLICE)'(y);
endmodule

// File: rtl/fracmul_accum.sv
// Shift-and-add accumulator for the partial products.
module fracmul_accum #(
    parameter int SLICE = 8,
    parameter int PW    = 32,
    parameter int SHW   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               add_en,
    input  logic [2*SLICE-1:0] partial,
    input  logic [SHW-1:0]     shamt,
    output logic [PW-1:0]      sum
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clear) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + (PW'(partial) << shamt);
        end
    end
endmodule

// File: rtl/fracmul_unit.sv
module fracmul_unit #(
    parameter int WIDTH    = 16,
    parameter int SLICE    = 8,
    parameter int NREG     = 16,
    parameter int SKIP_REG = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [WIDTH-1:0]        src_val,
    input  logic [WIDTH-1:0]        fac_val,
    input  logic [$clog2(NREG)-1:0] dst_sel,
    input  logic                    slow_mode,
    input  logic                    long_mode,
    output logic                    busy,
    output logic                    done,
    output logic [WIDTH-1:0]        result,
    output logic [WIDTH-1:0]        lo_result,
    output logic                    wr_en,
    output logic                    lo_wr_en,
    output logic [$clog2(NREG)-1:0] wr_idx,
    output logic                    flag_cy,
    output logic                    flag_s,
    output logic                    flag_z,
    output logic                    prefix_clr
);
    import fracmul_pkg::*;

    localparam int NSL    = WIDTH / SLICE;
    localparam int PASSES = NSL * NSL;
    localparam int IDXW   = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam int SW     = (NSL > 1) ? $clog2(NSL) : 1;
    localparam int PW     = 2 * WIDTH;
    localparam int SHW    = $clog2(PW);
    localparam int RW     = $clog2(NREG);

    fm_state_t state, state_nx;

    logic [WIDTH-1:0] mag_a, mag_b;
    logic             neg_q, slow_q, long_q;
    logic [RW-1:0]    dst_q;
    logic [IDXW-1:0]  pass_idx;
    logic             accept, last_pass, add_en;

    logic [SLICE-1:0]   a_sl [NSL];
    logic [SLICE-1:0]   b_sl [NSL];
    logic [SW-1:0]      a_i, b_i;
    logic [2*SLICE-1:0] partial;
    logic [SHW-1:0]     shamt;
    logic [PW-1:0]      acc, prod;

    function automatic logic [WIDTH-1:0] mag_of(input logic [WIDTH-1:0] v);
        return v[WIDTH-1] ? (~v + 1'b1) : v;
    endfunction

    assign accept    = (state == ST_IDLE) && start;
    assign last_pass = (pass_idx == IDXW'(PASSES - 1));
    assign add_en    = ((state == ST_PASS) && !slow_q) || (state == ST_HOLD);

    // Byte slices of the operand magnitudes
    for (genvar g = 0; g < NSL; g++) begin : g_slice
        assign a_sl[g] = mag_a[g*SLICE +: SLICE];
        assign b_sl[g] = mag_b[g*SLICE +: SLICE];
    end

    assign a_i   = SW'(pass_idx % NSL);
    assign b_i   = SW'(pass_idx / NSL);
    assign shamt = SHW'((32'(a_i) + 32'(b_i)) * SLICE);

    fracmul_slice_mul #(.SLICE(SLICE)) u_mul (
        .x (a_sl[a_i]),
        .y (b_sl[b_i]),
        .p (partial)
    );

    fracmul_accum #(.SLICE(SLICE), .PW(PW), .SHW(SHW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .add_en  (add_en),
        .partial (partial),
        .shamt   (shamt),
        .sum     (acc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_PASS;
            ST_PASS:  begin
                if (slow_q)         state_nx = ST_HOLD;
                else if (last_pass) state_nx = ST_FINAL;
                else                state_nx = ST_PASS;
            end
            ST_HOLD:  state_nx = last_pass ? ST_FINAL : ST_PASS;
            ST_FINAL: state_nx = ST_IDLE;
        endcase
    end

    // Operand capture and pass counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_a    <= '0;
            mag_b    <= '0;
            neg_q    <= 1'b0;
            slow_q   <= 1'b0;
            long_q   <= 1'b0;
            dst_q    <= '0;
            pass_idx <= '0;
        end else if (accept) begin
            mag_a    <= mag_of(src_val);
            mag_b    <= mag_of(fac_val);
            neg_q    <= src_val[WIDTH-1] ^ fac_val[WIDTH-1];
            slow_q   <= slow_mode;
            long_q   <= long_mode;
            dst_q    <= dst_sel;
            pass_idx <= '0;
        end else if (add_en && !last_pass) begin
            pass_idx <= pass_idx + 1'b1;
        end
    end

    assign prod = neg_q ? (~acc + 1'b1) : acc;

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_FINAL);
        result     = prod[PW-1:WIDTH];
        lo_result  = prod[WIDTH-1:0];
        flag_cy    = prod[WIDTH-1];
        flag_s     = prod[PW-1];
        flag_z     = (prod[PW-1:WIDTH] == '0);
        wr_idx     = dst_q;
        wr_en      = done && (dst_q != RW'(SKIP_REG));
        lo_wr_en   = done && long_q;
        prefix_clr = done;
    end
endmodule

// File: rtl/fracmul_unit_chk.sv
module fracmul_unit_chk #(
    parameter int WIDTH    = 16,
    parameter int SLICE    = 8,
    parameter int NREG     = 16,
    parameter int SKIP_REG = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    slow_mode,
    input logic                    busy,
    input logic                    done,
    input logic                    wr_en,
    input logic                    lo_wr_en,
    input logic [$clog2(NREG)-1:0] wr_idx
);
    localparam int NSL    = WIDTH / SLICE;
    localparam int PASSES = NSL * NSL;
    localparam int RW     = $clog2(NREG);

    logic [15:0] cyc;
    logic        slow_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc    <= '0;
            slow_c <= 1'b0;
        end else if (start && !busy) begin
            cyc    <= '0;
            slow_c <= slow_mode;
        end else if (busy) begin
            cyc <= cyc + 1'b1;
        end
    end

    // R5 and R6: completion arrives after the mode-dependent number of cycles
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc == (slow_c ? 16'(2*PASSES) : 16'(PASSES))));

    p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_dest_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_idx));

    p_skip_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (done && (wr_idx != RW'(SKIP_REG))));

    p_lo_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_en |-> done);
endmodule

bind fracmul_unit fracmul_unit_chk #(
    .WIDTH(WIDTH), .SLICE(SLICE), .NREG(NREG), .SKIP_REG(SKIP_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .slow_mode (slow_mode),
    .busy      (busy),
    .done      (done),
    .wr_en     (wr_en),
    .lo_wr_en  (lo_wr_en),
    .wr_idx    (wr_idx)
);

// File: tb/fracmul_unit_test.sv
`timescale 1ns/1ps
module fracmul_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] src_val = '0;
    logic [15:0] fac_val = '0;
    logic [3:0]  dst_sel = '0;
    logic        slow_mode = 1'b0;
    logic        long_mode = 1'b0;
    logic        busy, done, wr_en, lo_wr_en, flag_cy, flag_s, flag_z, prefix_clr;
    logic [15:0] result, lo_result;
    logic [3:0]  wr_idx;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    fracmul_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_val(src_val), .fac_val(fac_val),
        .dst_sel(dst_sel), .slow_mode(slow_mode), .long_mode(long_mode),
        .busy(busy), .done(done), .result(result), .lo_result(lo_result),
        .wr_en(wr_en), .lo_wr_en(lo_wr_en), .wr_idx(wr_idx),
        .flag_cy(flag_cy), .flag_s(flag_s), .flag_z(flag_z), .prefix_clr(prefix_clr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic [3:0] d,
                          input bit slow, input bit lng, input bit poke);
        logic signed [31:0] p;
        int lat;
        p   = $signed(a) * $signed(b);
        lat = slow ? 8 : 4;
        @(negedge clk);
        src_val = a; fac_val = b; dst_sel = d; slow_mode = slow; long_mode = lng; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R7", "busy after start", {30'd0, busy, done}, 32'd2);
        for (int k = 1; k < lat; k++) begin
            if (poke && k == 1) begin
                // R8: a new request during the run must be ignored
                src_val = ~a; fac_val = a ^ 16'h5a5a; dst_sel = d + 4'd1;
                slow_mode = !slow; long_mode = !lng; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            chk(busy && !done, slow ? "R6" : "R5", "not yet done", {30'd0, busy, done}, 32'd2);
        end
        @(negedge clk);
        chk(done && busy, slow ? "R6" : "R5", "done due", {30'd0, busy, done}, 32'd3);
        chk(result == p[31:16], poke ? "R8" : "R2", "result", {16'd0, result}, {16'd0, p[31:16]});
        chk(flag_cy == p[15], "R3", "carry", {31'd0, flag_cy}, {31'd0, p[15]});
        chk(flag_s == p[31] && flag_z == (p[31:16] == 16'd0), "R4", "sign/zero",
            {30'd0, flag_s, flag_z}, {30'd0, p[31], p[31:16] == 16'd0});
        chk(wr_en == (d != 4'd4) && wr_idx == d, "R9", "write strobe/index",
            {27'd0, wr_en, wr_idx}, {27'd0, d != 4'd4, d});
        chk(lo_wr_en == lng, "R10", "low strobe", {31'd0, lo_wr_en}, {31'd0, lng});
        if (lng)
            chk(lo_result == p[15:0], "R10", "low half", {16'd0, lo_result}, {16'd0, p[15:0]});
        chk(prefix_clr == 1'b1, "R11", "prefix clear in done cycle", {31'd0, prefix_clr}, 32'd1);
        @(negedge clk);
        chk(!busy && !done && !wr_en && !lo_wr_en && !prefix_clr, "R7", "idle after done",
            {27'd0, busy, done, wr_en, lo_wr_en, prefix_clr}, 32'd0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] cv [10];
        logic [31:0] lcg;
        cv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000,
               16'h00FF, 16'h0100, 16'hFF00, 16'h8001, 16'h1234};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en && !lo_wr_en && !prefix_clr, "R1", "outputs in reset",
            {27'd0, busy, done, wr_en, lo_wr_en, prefix_clr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !wr_en && !prefix_clr, "R1", "outputs after reset",
            {28'd0, busy, done, wr_en, prefix_clr}, 32'd0);

        // R2 corner: most negative squared
        run_op(16'h8000, 16'h8000, 4'd1, 1'b0, 1'b0, 1'b0);
        chk(result == 16'h4000, "R2", "min*min high half", {16'd0, result}, 32'h4000);

        // Corner grid in both speeds
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++) begin
                run_op(cv[i], cv[j], 4'((i + j) % 16), 1'b0, j[0], 1'b0);
                run_op(cv[i], cv[j], 4'((i * 3 + j) % 16), 1'b1, i[0], 1'b0);
            end

        // R9: every destination index
        for (int d = 0; d < 16; d++) begin
            run_op(16'h7FFF, 16'h8000, 4'(d), 1'b0, 1'b0, 1'b0);
            run_op(16'hC000, 16'h4000, 4'(d), 1'b1, 1'b1, 1'b0);
        end

        // R8: start requests while busy
        for (int i = 0; i < 10; i++) begin
            run_op(cv[i], 16'h7FFF - 16'(i), 4'(i), 1'b0, 1'b0, 1'b1);
            run_op(cv[i], 16'h8000 + 16'(i), 4'(i + 3), 1'b1, 1'b1, 1'b1);
        end

        // Stepped sweep of the source operand
        for (int a = 0; a < 65536; a += 257) begin
            run_op(16'(a), 16'h8000, 4'd4, 1'b0, 1'b1, 1'b0);
            run_op(16'(a), 16'hFFFF, 4'd2, 1'b0, 1'b0, 1'b0);
            run_op(16'(a), 16'h6789, 4'd7, 1'b1, 1'b0, 1'b0);
        end

        // Pseudo-random stream
        lcg = 32'h1ACE_B00C;
        for (int n = 0; n < 1500; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            run_op(lcg[31:16], lcg[15:0] ^ lcg[31:16] << 3, lcg[7:4], lcg[9], lcg[11], n % 50 == 7);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule